// File: doc/BRIEF.md
# Serial Flash Status Auto-Poll Engine

This block issues a status-read transaction to a serial flash over a single-lane SPI link (mode 0: SCK idles low, data is launched on the falling edge and sampled on the rising edge). It repeats that transaction until the status word it reads, compared under a mask, equals an expected value. The processor writes the command, the optional address bytes, the dummy-cycle count, the expected value, the mask and the inter-poll gap. It then pulses `start` and does nothing until the engine raises its end flag, or until it decides to pulse `stop`.

Each poll is one chip-select window: command bits first, then address bytes, then dummy cycles, then the status bits. A 16-bit command mode widens the status word to 16 bits as well. After every poll, the word just received is copied into a status register that can be read at any time. When there is no match, chip select goes high for a programmable gap and the same transaction runs again. When there is a match, the engine stops, holds the end flag, and can raise an interrupt.

Top module: `flash_autopoll`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, `busy` is 0, `end_flag` is 0, `irq` is 0 and `rt_status` is 0.
- R2: A `start` pulse in idle begins a poll frame. `cs_n` goes low. The command goes out MSB first on `mosi`: all 16 bits of `cmd_code` when `wide16`=1, otherwise only `cmd_code[7:0]`. Next come the low `addr_len` bytes of `addr_val`, MSB first (0 to 4 bytes; 0 skips the phase). Next come `dummy_len` SCK cycles. Last, the status bits are sampled from `miso` on rising SCK edges. Each SCK cycle lasts two `clk` cycles, and `sck` is low whenever `cs_n` is high.
- R3: A poll matches when `((status ^ stat_expect) & stat_mask)` is zero, taken over the status width. In 8-bit mode, bits 15:8 of `stat_expect` and `stat_mask` have no effect.
- R4: At the end of every poll, `rt_status` takes the word just received, MSB first. In 8-bit mode, bits 15:8 of `rt_status` are 0. `rt_status` changes only on the cycle where `cs_n` rises.
- R5: After a poll that does not match, `cs_n` stays high for max(`gap_len`, 2) SCK cycles (twice that many `clk` cycles). The identical frame then repeats.
- R6: If the first status word already matches, the end flag is set after exactly one chip-select window.
- R7: On a match, `end_flag` rises in the same cycle that `busy` falls and `cs_n` rises. It stays at 1 until the next `start`, which clears it.
- R8: `irq` is 1 exactly when `end_flag` is 1 and `irq_en` is 1.
- R9: A `stop` pulse while busy makes the next cycle idle: `busy`=0, `cs_n`=1, `sck`=0. `end_flag` stays 0.
- R10: A `start` pulse while busy has no effect: the running sequence keeps its poll count and result.
- R11: With `wide16`=1, the status word is 16 bits wide and is compared and stored in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (pulse, taken only in idle) |
| stop | input | 1 | Abort polling (pulse) |
| wide16 | input | 1 | 1: 16-bit command and status, 0: 8-bit |
| cmd_code | input | 16 | Status-read command |
| addr_val | input | 32 | Address sent after the command |
| addr_len | input | 3 | Address byte count, 0 to 4 |
| dummy_len | input | 6 | Dummy SCK cycles before status |
| stat_expect | input | 16 | Expected status value |
| stat_mask | input | 16 | Status bits that take part in the compare |
| gap_len | input | 8 | Chip-select-high SCK cycles between polls (min 2) |
| irq_en | input | 1 | Interrupt enable for the end flag |
| miso | input | 1 | Serial data from flash |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| busy | output | 1 | Polling in progress |
| end_flag | output | 1 | Match found (sticky until next start) |
| irq | output | 1 | Interrupt request |
| rt_status | output | 16 | Last status word received |

## Verification
A corrupted bit counter or phase state shows up within one frame. The bench's flash model then sees a command or address that differs from the one programmed, or returns status bits shifted out of place, so `rt_status` or the poll count is wrong when the end flag rises. A gap counter in the wrong state shows up at the next poll boundary, as a chip-select-high interval that differs from twice the effective gap. A wrong compare shows up as an end flag one or more polls early or late. A lost abort shows up on the very next cycle, because `busy` or `cs_n` is not idle.

// File: rtl/autopoll_pkg.sv
// Shared types for the status auto-poll engine.
// Assumes: phases run in the fixed order command, address, dummy, status.
package autopoll_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADR,
        PH_DMY,
        PH_DAT,
        PH_GAP
    } phase_t;

    // Phase that follows a finished serial phase; empty phases are skipped.
    function automatic phase_t phase_after(input phase_t cur, input logic no_adr,
                                           input logic no_dmy);
        phase_t nxt;
        case (cur)
            PH_CMD:  nxt = no_adr ? (no_dmy ? PH_DAT : PH_DMY) : PH_ADR;
            PH_ADR:  nxt = no_dmy ? PH_DAT : PH_DMY;
            default: nxt = PH_DAT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/autopoll_cmp.sv
// Masked status comparator.
// Does: reports a match when every enabled, in-width bit of the received
// word equals the expected bit. Assumes the upper byte is ignored in 8-bit mode.
module autopoll_cmp #(
    parameter int STAT_W = 16
) (
    input  logic [STAT_W-1:0] rx_word,
    input  logic [STAT_W-1:0] expect_val,
    input  logic [STAT_W-1:0] mask_val,
    input  logic              wide,
    output logic              match
);
    logic [STAT_W-1:0] bit_ok;

    // Per-bit agreement: a bit passes when masked off, out of width or equal.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i < 8) begin : g_low
            assign bit_ok[i] = ~mask_val[i] | (rx_word[i] ~^ expect_val[i]);
        end else begin : g_high
            assign bit_ok[i] = ~wide | ~mask_val[i] | (rx_word[i] ~^ expect_val[i]);
        end
    end

    assign match = &bit_ok;

endmodule

// File: rtl/autopoll_gap.sv
// Inter-poll chip-select gap timer.
// Does: after a load, counts 2*max(gap_sel, MIN_GAP) clk cycles (one SCK
// cycle is two clk cycles) and pulses done on the last. Assumes clr aborts.
module autopoll_gap #(
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic [GAP_W-1:0] gap_sel,
    output logic             done
);
    localparam int CW = GAP_W + 1;

    logic [GAP_W-1:0] eff_gap;
    logic [CW-1:0]    cnt;
    logic             active;

    // Apply the lower bound on the gap length.
    always_comb begin
        eff_gap = (gap_sel < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : gap_sel;
    end

    // Down-counter covering the whole gap window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (clr) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= {eff_gap, 1'b0} - CW'(1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - CW'(1);
        end
    end

    assign done = active && (cnt == '0);

endmodule

// File: rtl/autopoll_seq.sv
// Serial frame sequencer for the status poll.
// Does: drives chip select, SCK at half the clk rate (mode 0), and the
// command, address, dummy and status phases; decides between repeat and end.
// Assumes: configuration inputs stay stable while busy.
module autopoll_seq
    import autopoll_pkg::*;
#(
    parameter int STAT_W     = 16,
    parameter int ADDR_BYTES = 4,
    parameter int DUMMY_W    = 6,
    parameter int NB_W       = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    stop,
    input  logic                    wide,
    input  logic [STAT_W-1:0]       cmd_code,
    input  logic [ADDR_BYTES*8-1:0] addr_val,
    input  logic [NB_W-1:0]         addr_len,
    input  logic [DUMMY_W-1:0]      dummy_len,
    input  logic                    miso,
    input  logic                    match,
    input  logic                    gap_done,
    output logic                    gap_load,
    output logic [STAT_W-1:0]       rx_word,
    output logic                    sck,
    output logic                    cs_n,
    output logic                    mosi,
    output logic                    busy,
    output logic                    end_flag,
    output logic [STAT_W-1:0]       rt_status
);
    localparam int TXW   = ADDR_BYTES * 8;
    localparam int CNT_W = $clog2(TXW + (1 << DUMMY_W)) + 1;

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ph_len;
    logic             half;
    logic [TXW-1:0]   tx_sh;
    logic [NB_W-1:0]  nb_eff;
    logic [TXW-1:0]   cmd_al;
    logic [TXW-1:0]   adr_al;
    logic             last_bit;
    logic             fin_dat;
    phase_t           nxt_ph;

    // Left-align the command and address words for MSB-first shifting.
    always_comb begin
        nb_eff = (addr_len > NB_W'(ADDR_BYTES)) ? NB_W'(ADDR_BYTES) : addr_len;
        cmd_al = wide ? (TXW'(cmd_code) << (TXW - STAT_W))
                      : (TXW'(cmd_code[7:0]) << (TXW - 8));
        adr_al = addr_val << (8 * (ADDR_BYTES - int'(nb_eff)));
    end

    // Bit length of the current serial phase and the phase that follows it.
    always_comb begin
        case (ph)
            PH_CMD:  ph_len = wide ? CNT_W'(STAT_W) : CNT_W'(8);
            PH_ADR:  ph_len = CNT_W'(nb_eff) << 3;
            PH_DMY:  ph_len = CNT_W'(dummy_len);
            PH_DAT:  ph_len = wide ? CNT_W'(STAT_W) : CNT_W'(8);
            default: ph_len = CNT_W'(1);
        endcase
        last_bit = (cnt == ph_len - CNT_W'(1));
        nxt_ph   = phase_after(ph, nb_eff == '0, dummy_len == '0);
        fin_dat  = (ph == PH_DAT) && half && last_bit;
    end

    // Ask the gap timer to run when a poll ends without a match.
    assign gap_load = fin_dat && !match && !stop;

    // Main frame state machine: phases, SCK halves, shifting and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            half      <= 1'b0;
            sck       <= 1'b0;
            cs_n      <= 1'b1;
            tx_sh     <= '0;
            rx_word   <= '0;
            end_flag  <= 1'b0;
            rt_status <= '0;
        end else if (stop && ph != PH_IDLE) begin
            ph   <= PH_IDLE;
            half <= 1'b0;
            sck  <= 1'b0;
            cs_n <= 1'b1;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        end_flag <= 1'b0;
                        ph       <= PH_CMD;
                        cs_n     <= 1'b0;
                        cnt      <= '0;
                        half     <= 1'b0;
                        tx_sh    <= cmd_al;
                    end
                end
                PH_GAP: begin
                    if (gap_done) begin
                        ph    <= PH_CMD;
                        cs_n  <= 1'b0;
                        cnt   <= '0;
                        half  <= 1'b0;
                        tx_sh <= cmd_al;
                    end
                end
                default: begin
                    if (!half) begin
                        sck  <= 1'b1;
                        half <= 1'b1;
                        if (ph == PH_DAT) rx_word <= {rx_word[STAT_W-2:0], miso};
                    end else begin
                        sck  <= 1'b0;
                        half <= 1'b0;
                        if (!last_bit) begin
                            cnt   <= cnt + CNT_W'(1);
                            tx_sh <= tx_sh << 1;
                        end else if (ph == PH_DAT) begin
                            rt_status <= rx_word;
                            cs_n      <= 1'b1;
                            if (match) begin
                                end_flag <= 1'b1;
                                ph       <= PH_IDLE;
                            end else begin
                                ph <= PH_GAP;
                            end
                        end else begin
                            ph  <= nxt_ph;
                            cnt <= '0;
                            if (nxt_ph == PH_ADR) tx_sh <= adr_al;
                            else                  tx_sh <= '0;
                            if (nxt_ph == PH_DAT) rx_word <= '0;
                        end
                    end
                end
            endcase
        end
    end

    assign mosi = (ph == PH_CMD || ph == PH_ADR) ? tx_sh[TXW-1] : 1'b0;
    assign busy = (ph != PH_IDLE);

endmodule

// File: rtl/flash_autopoll.sv
// Top of the serial flash status auto-poll engine.
// Does: ties the frame sequencer, masked comparator and gap timer together
// and gates the end flag onto the interrupt line.
// Assumes: one flash device, single-lane SPI mode 0, inputs stable while busy.
module flash_autopoll #(
    parameter int STAT_W     = 16,
    parameter int ADDR_BYTES = 4,
    parameter int DUMMY_W    = 6,
    parameter int GAP_W      = 8,
    parameter int MIN_GAP    = 2,
    parameter int NB_W       = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    stop,
    input  logic                    wide16,
    input  logic [STAT_W-1:0]       cmd_code,
    input  logic [ADDR_BYTES*8-1:0] addr_val,
    input  logic [NB_W-1:0]         addr_len,
    input  logic [DUMMY_W-1:0]      dummy_len,
    input  logic [STAT_W-1:0]       stat_expect,
    input  logic [STAT_W-1:0]       stat_mask,
    input  logic [GAP_W-1:0]        gap_len,
    input  logic                    irq_en,
    input  logic                    miso,
    output logic                    sck,
    output logic                    cs_n,
    output logic                    mosi,
    output logic                    busy,
    output logic                    end_flag,
    output logic                    irq,
    output logic [STAT_W-1:0]       rt_status
);
    logic              match;
    logic              gap_load;
    logic              gap_done;
    logic [STAT_W-1:0] rx_word;

    autopoll_seq #(
        .STAT_W(STAT_W), .ADDR_BYTES(ADDR_BYTES), .DUMMY_W(DUMMY_W), .NB_W(NB_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .wide(wide16),
        .cmd_code(cmd_code), .addr_val(addr_val), .addr_len(addr_len),
        .dummy_len(dummy_len), .miso(miso), .match(match), .gap_done(gap_done),
        .gap_load(gap_load), .rx_word(rx_word), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .busy(busy), .end_flag(end_flag), .rt_status(rt_status)
    );

    autopoll_cmp #(.STAT_W(STAT_W)) u_cmp (
        .rx_word(rx_word), .expect_val(stat_expect), .mask_val(stat_mask),
        .wide(wide16), .match(match)
    );

    autopoll_gap #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .clr(stop),
        .gap_sel(gap_len), .done(gap_done)
    );

    assign irq = end_flag & irq_en;

endmodule

// File: rtl/autopoll_chk.sv
// Protocol checker for the status auto-poll engine, bound to its top.
// Does: watches the ports for chip-select, SCK, end-flag and abort rules.
module autopoll_chk #(
    parameter int STAT_W  = 16,
    parameter int MIN_GAP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stop,
    input logic              sck,
    input logic              cs_n,
    input logic              busy,
    input logic              end_flag,
    input logic              irq,
    input logic [STAT_W-1:0] rt_status
);
    logic [7:0] hi_cnt;

    // Length of the current chip-select-high stretch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_cnt <= '0;
        else if (!cs_n)              hi_cnt <= '0;
        else if (hi_cnt != 8'hFF)    hi_cnt <= hi_cnt + 8'd1;
    end

    assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_rt_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cs_n) |-> $stable(rt_status));

    assert_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) && $past(busy) |-> hi_cnt >= 8'(2 * MIN_GAP));

    assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> !busy && cs_n);

    assert_end_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        end_flag && !start |=> end_flag);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> end_flag);

    assert_stop_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop && busy |=> !busy && cs_n && !sck && !end_flag);

endmodule

bind flash_autopoll autopoll_chk #(.STAT_W(STAT_W), .MIN_GAP(MIN_GAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .sck(sck),
    .cs_n(cs_n), .busy(busy), .end_flag(end_flag), .irq(irq),
    .rt_status(rt_status)
);

// File: tb/flash_autopoll_bench.sv
// Scoreboard bench: a driver task queues the expected outcome of each poll
// run, a flash model answers frames, and a monitor compares on end flag.
module flash_autopoll_bench;
    localparam int CLK_NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    logic        start = 0, stop = 0, wide16 = 0, irq_en = 0, miso = 0;
    logic [15:0] cmd_code = 0, stat_expect = 0, stat_mask = 0;
    logic [31:0] addr_val = 0;
    logic [2:0]  addr_len = 0;
    logic [5:0]  dummy_len = 0;
    logic [7:0]  gap_len = 0;
    logic        sck, cs_n, mosi, busy, end_flag, irq;
    logic [15:0] rt_status;

    flash_autopoll u_flash_autopoll (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .wide16(wide16),
        .cmd_code(cmd_code), .addr_val(addr_val), .addr_len(addr_len),
        .dummy_len(dummy_len), .stat_expect(stat_expect), .stat_mask(stat_mask),
        .gap_len(gap_len), .irq_en(irq_en), .miso(miso), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .busy(busy), .end_flag(end_flag), .irq(irq),
        .rt_status(rt_status)
    );

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash model: status words returned per chip-select window.
    logic [15:0] sseq [4];
    int          nseq = 1, sidx = 0, polls = 0, rcnt = 0;
    logic [15:0] cur_stat = 0, cap_cmd = 0;
    logic [31:0] cap_addr = 0;

    always @(negedge cs_n) begin
        rcnt     = 0;
        cap_cmd  = 0;
        cap_addr = 0;
        polls++;
        cur_stat = sseq[(sidx < nseq) ? sidx : nseq - 1];
        sidx++;
    end

    always @(posedge sck) begin
        int cw;
        cw = wide16 ? 16 : 8;
        if (rcnt < cw) cap_cmd = {cap_cmd[14:0], mosi};
        else if (rcnt < cw + int'(addr_len) * 8) cap_addr = {cap_addr[30:0], mosi};
        rcnt++;
    end

    always @(negedge sck) begin
        int cw, pre;
        cw  = wide16 ? 16 : 8;
        pre = cw + int'(addr_len) * 8 + int'(dummy_len);
        if (rcnt >= pre && rcnt < pre + cw) miso = cur_stat[cw - 1 - (rcnt - pre)];
    end

    // Chip-select-high length between polls, in clk cycles.
    int hcnt = 0, last_gap = 0;
    always @(negedge clk) begin
        if (busy && cs_n) hcnt++;
        else if (!cs_n && hcnt > 0) begin
            last_gap = hcnt;
            hcnt = 0;
        end
    end

    typedef struct {
        logic [15:0] rt;
        int          npoll;
        logic [15:0] cmd;
        logic [31:0] addr;
        int          gap;
        logic        irqv;
    } exp_t;
    exp_t sb [$];

    // Monitor: pop and compare when the end flag rises.
    logic end_d = 0;
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && end_flag && !end_d) begin
            if (sb.size() == 0) begin
                check_eq("R7 unexpected end flag", 1, 0);
            end else begin
                e = sb.pop_front();
                check_eq("R4 R11 rt_status", rt_status, e.rt);
                check_eq("R5 R6 poll count", polls, e.npoll);
                check_eq("R2 command bits", cap_cmd, e.cmd);
                check_eq("R2 address bits", cap_addr, e.addr);
                check_eq("R5 gap clk cycles", last_gap, e.gap);
                check_eq("R7 busy low at end", busy, 0);
                check_eq("R8 irq at end", irq, e.irqv);
            end
        end
        end_d = end_flag;
    end

    task automatic run_poll(input bit w, input logic [15:0] c, input logic [2:0] nb,
                            input logic [31:0] a, input logic [5:0] d,
                            input logic [15:0] ev, input logic [15:0] mv,
                            input logic [7:0] g, input bit ie, input int exp_polls,
                            input logic [15:0] exp_rt, input bit poke_start);
        exp_t x;
        int   eff;
        int   t;
        logic [63:0] amask;
        @(negedge clk);
        wide16 = w; cmd_code = c; addr_len = nb; addr_val = a; dummy_len = d;
        stat_expect = ev; stat_mask = mv; gap_len = g; irq_en = ie;
        sidx = 0; polls = 0; hcnt = 0; last_gap = 0;
        eff    = (g < 2) ? 2 : int'(g);
        amask  = (64'd1 << (8 * nb)) - 64'd1;
        x.rt    = exp_rt;
        x.npoll = exp_polls;
        x.cmd   = w ? c : {8'h00, c[7:0]};
        x.addr  = a & amask[31:0];
        x.gap   = (exp_polls > 1) ? 2 * eff : 0;
        x.irqv  = ie;
        sb.push_back(x);
        start = 1;
        @(negedge clk);
        start = 0;
        check_eq("R7 start clears end flag", end_flag, 0);
        check_eq("R2 cs_n low after start", cs_n, 0);
        if (poke_start) begin
            repeat (30) @(negedge clk);
            check_eq("R10 still busy before extra start", busy, 1);
            start = 1;
            @(negedge clk);
            start = 0;
        end
        t = 0;
        while (!end_flag && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check_eq("R7 end flag reached", end_flag, 1);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done_run) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 cs_n", cs_n, 1);
        check_eq("R1 sck", sck, 0);
        check_eq("R1 mosi", mosi, 0);
        check_eq("R1 busy", busy, 0);
        check_eq("R1 end_flag", end_flag, 0);
        check_eq("R1 irq", irq, 0);
        check_eq("R1 rt_status", rt_status, 0);

        // R3 R5 R10: bit0 must clear; third word matches; extra start mid-run
        sseq[0] = 16'h0003; sseq[1] = 16'h0041; sseq[2] = 16'h0042; nseq = 3;
        run_poll(0, 16'h0005, 0, 0, 0, 16'h0000, 16'h0001, 0, 0, 3, 16'h0042, 1);

        // R6 R8: first word matches, interrupt enabled
        sseq[0] = 16'h0080; nseq = 1;
        run_poll(0, 16'h0035, 0, 0, 0, 16'h0080, 16'h0080, 9, 1, 1, 16'h0080, 0);
        repeat (20) @(negedge clk);
        check_eq("R7 end flag held", end_flag, 1);
        check_eq("R8 irq held", irq, 1);
        check_eq("R7 cs_n idle after end", cs_n, 1);

        // R2 R11: 16-bit command and status, 3 address bytes, 8 dummies, gap 5
        sseq[0] = 16'h0001; sseq[1] = 16'h8001; sseq[2] = 16'h8000; nseq = 3;
        run_poll(1, 16'h70AB, 3, 32'hAB123456, 8, 16'h8000, 16'h8001, 5, 0, 3,
                 16'h8000, 0);

        // R3 R4 R8: 8-bit mode ignores upper expect/mask; 1 address byte; gap 1 -> 2
        sseq[0] = 16'h003E; sseq[1] = 16'h00AF; nseq = 2;
        run_poll(0, 16'hEE0F, 1, 32'h00000077, 4, 16'hAA0F, 16'hFF0F, 1, 0, 2,
                 16'h00AF, 0);
        check_eq("R8 irq masked", irq, 0);
        check_eq("R4 upper byte zero", rt_status[15:8], 0);

        // R9: never-matching poll aborted by stop
        sseq[0] = 16'h0000; nseq = 1;
        @(negedge clk);
        wide16 = 0; cmd_code = 16'h0005; addr_len = 0; dummy_len = 0;
        stat_expect = 16'h0001; stat_mask = 16'h0001; gap_len = 3; sidx = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (151) @(negedge clk);
        check_eq("R9 busy before stop", busy, 1);
        stop = 1;
        @(negedge clk);
        stop = 0;
        check_eq("R9 busy after stop", busy, 0);
        check_eq("R9 cs_n after stop", cs_n, 1);
        check_eq("R9 sck after stop", sck, 0);
        check_eq("R9 end flag after stop", end_flag, 0);
        repeat (40) @(negedge clk);
        check_eq("R9 stays idle", {busy, cs_n, end_flag}, 3'b010);
        check_eq("R9 scoreboard drained", sb.size(), 0);

        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule